// File: doc/BRIEF.md
# Multi-Cell Wilkinson Ramp Converter Back End

This block is the digital half of a single-slope (Wilkinson) converter serving one channel of a switched-capacitor sampling array. Once a conversion is started, one shared counter advances on every clock of the conversion window. Every storage cell has its own comparator input. The first time that input is seen high inside the window, the cell takes a snapshot of the shared count. A cell whose comparator never fires before the window closes is filled with the full-scale code, and its overcount flag is set.

After the window closes, a single one-hot token walks the cells from the lowest index to the highest. On each clock where the read enable is high, the cell that holds the token places its 13-bit word (12-bit count plus overcount flag) on the output bus, and a valid strobe marks that word. A done flag goes up together with the final word. It stays up until a new conversion is accepted, which clears every cell. A mode input selects a shorter window for a quicker conversion at reduced resolution.

Top module: `ramp_conv_backend`

## Requirements
- R1: While reset is asserted and directly after it, dataValid, done, dataOut and overOut are all 0. A read enable given before any conversion produces no valid word.
- R2: Each cell stores the count equal to the number of window clocks that went by before the clock edge at which its comparator was first sampled high. The first window edge stores 0.
- R3: A comparator that is already high when conversion starts stores a count of 0.
- R4: Only the first assertion of a comparator within a window is captured. Dropping the input and raising it again later does not change the stored word.
- R5: In full mode (shortMode=0 at start) the window lasts 4096 clocks, and a cell can store counts 0 to 4095. A cell whose comparator has not fired by then reads back dataOut=4095 with overOut=1. A captured count always reads back with overOut=0.
- R6: In short mode (shortMode=1 at start) the window lasts SHORT_LIMIT=1120 clocks. A cell that fires on count 1119 keeps that value, and a cell that would fire on count 1120 or later reads 4095 with overOut=1. The mode is latched when the conversion is accepted, so later changes to shortMode are ignored.
- R7: Readout returns cell 0 first, then each higher index in turn, one word per clock while readEn is high. Each word appears on dataOut/overOut with dataValid=1 one clock after the edge that reads it. No more than 256 words are produced per conversion.
- R8: While readEn is low during readout, dataValid is 0, the bus holds its value and the token stays in place. Readout then continues with the next cell.
- R9: done rises in the same cycle as the valid strobe of cell 255 and stays at 1. No further valid words appear until a new conversion is accepted.
- R10: A convStart accepted while idle or done clears done and all cells. The next conversion then produces fresh values in every cell.
- R11: convStart is ignored while a conversion window or a readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and readout clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| convStart | input | 1 | Starts a conversion when idle or done |
| shortMode | input | 1 | Selects the reduced window, latched at start |
| cmpIn | input | 256 | One comparator output per storage cell |
| readEn | input | 1 | Allows one cell to be read per clock |
| dataOut | output | 12 | Count of the cell being read |
| overOut | output | 1 | Overcount flag of the cell being read |
| dataValid | output | 1 | Marks a valid word on the bus |
| done | output | 1 | All cells have been read |

## Verification
A comparator that is high at the n-th window edge after the start edge stores n-1, since the counter register is one edge behind. The bench therefore drives each comparator from its own edge count and compares against the threshold it chose, with no offset beyond that one. The window closes on edge 4096 or 1120 after the start edge. Every word read appears one edge after the read edge that selected it, and done appears on that same edge, so each check samples at the falling edge after the edge that caused it. The same one-cycle accounting is used to confirm that pauses, ignored starts and mode changes leave the bus unchanged.

// File: rtl/rampconv_pkg.sv
package rampconv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } convState_t;

  // Strobes from the sequencer to the cell datapath
  typedef struct packed {
    logic clearAll;   // start accepted: wipe every cell
    logic sampleEn;   // conversion window open this cycle
    logic windowEnd;  // last window cycle: fill unfired cells
    logic readStep;   // present token cell and advance
  } convStrobe_t;

endpackage

// File: rtl/rampconv_ctrl.sv
module rampconv_ctrl
  import rampconv_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SHORT_LIMIT = 1120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convStart,
  input  logic             shortMode,
  input  logic             readEn,
  input  logic             lastCell,
  output logic [CNT_W-1:0] count,
  output convStrobe_t      stb,
  output logic             done
);

  localparam logic [CNT_W-1:0] FULL_TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SHORT_TOP = CNT_W'(SHORT_LIMIT - 1);

  convState_t      state;
  logic            shortLat;
  logic [CNT_W-1:0] limit;
  logic            startOk;
  logic            atLimit;

  assign limit   = shortLat ? SHORT_TOP : FULL_TOP;
  assign startOk = convStart && ((state == ST_IDLE) || (state == ST_DONE));
  assign atLimit = (state == ST_CONV) && (count == limit);

  always_comb begin
    stb.clearAll  = startOk;
    stb.sampleEn  = (state == ST_CONV);
    stb.windowEnd = atLimit;
    stb.readStep  = (state == ST_READ) && readEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      count    <= '0;
      shortLat <= 1'b0;
      done     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (startOk) begin
            state    <= ST_CONV;
            count    <= '0;
            shortLat <= shortMode;
            done     <= 1'b0;
          end
        end
        ST_CONV: begin
          count <= count + 1'b1;
          if (atLimit) state <= ST_READ;
        end
        ST_READ: begin
          if (readEn && lastCell) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rampconv_cells.sv
module rampconv_cells
  import rampconv_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int NUM_CELLS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  convStrobe_t          stb,
  input  logic [CNT_W-1:0]     count,
  input  logic [NUM_CELLS-1:0] cmpIn,
  output logic                 lastCell,
  output logic [CNT_W-1:0]     dataOut,
  output logic                 overOut,
  output logic                 dataValid
);

  localparam int WORD_W = CNT_W + 1;
  localparam logic [WORD_W-1:0] OVER_WORD = {1'b1, {CNT_W{1'b1}}};

  logic [WORD_W-1:0]    cellWord [NUM_CELLS];
  logic [NUM_CELLS-1:0] captured;
  logic [NUM_CELLS-1:0] token;
  logic [WORD_W-1:0]    busWord;

  // Per-cell static storage: first comparator hit wins, else overcount fill
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cellWord[c] <= '0;
        captured[c] <= 1'b0;
      end else if (stb.clearAll) begin
        cellWord[c] <= '0;
        captured[c] <= 1'b0;
      end else if (stb.sampleEn && !captured[c] && cmpIn[c]) begin
        cellWord[c] <= {1'b0, count};
        captured[c] <= 1'b1;
      end else if (stb.windowEnd && !captured[c]) begin
        cellWord[c] <= OVER_WORD;
        captured[c] <= 1'b1;
      end
    end
  end

  // One-hot readout token
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      token <= '0;
    end else if (stb.clearAll) begin
      token <= '0;
    end else if (stb.windowEnd) begin
      token <= NUM_CELLS'(1);
    end else if (stb.readStep) begin
      token <= token << 1;
    end
  end

  assign lastCell = token[NUM_CELLS-1];

  // Shared bus: token-gated OR of all cell words
  always_comb begin
    busWord = '0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      busWord = busWord | (cellWord[c] & {WORD_W{token[c]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut   <= '0;
      overOut   <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= stb.readStep;
      if (stb.readStep) {overOut, dataOut} <= busWord;
    end
  end

endmodule

// File: rtl/ramp_conv_backend.sv
module ramp_conv_backend
  import rampconv_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int NUM_CELLS   = 256,
  parameter int SHORT_LIMIT = 1120
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 convStart,
  input  logic                 shortMode,
  input  logic [NUM_CELLS-1:0] cmpIn,
  input  logic                 readEn,
  output logic [CNT_W-1:0]     dataOut,
  output logic                 overOut,
  output logic                 dataValid,
  output logic                 done
);

  convStrobe_t      stb;
  logic [CNT_W-1:0] count;
  logic             lastCell;

  rampconv_ctrl #(
    .CNT_W      (CNT_W),
    .SHORT_LIMIT(SHORT_LIMIT)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .convStart(convStart),
    .shortMode(shortMode),
    .readEn   (readEn),
    .lastCell (lastCell),
    .count    (count),
    .stb      (stb),
    .done     (done)
  );

  rampconv_cells #(
    .CNT_W    (CNT_W),
    .NUM_CELLS(NUM_CELLS)
  ) cells_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .count    (count),
    .cmpIn    (cmpIn),
    .lastCell (lastCell),
    .dataOut  (dataOut),
    .overOut  (overOut),
    .dataValid(dataValid)
  );

endmodule

// File: rtl/ramp_conv_backend_chk.sv
module ramp_conv_backend_chk #(
  parameter int CNT_W     = 12,
  parameter int NUM_CELLS = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             convStart,
  input logic             readEn,
  input logic [CNT_W-1:0] dataOut,
  input logic             overOut,
  input logic             dataValid,
  input logic             done
);

  localparam int SEEN_W = $clog2(NUM_CELLS) + 2;
  logic [SEEN_W-1:0] validSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validSeen <= '0;
    else if (done && convStart) validSeen <= '0;
    else if (dataValid) validSeen <= validSeen + 1'b1;
  end

  // R7: a word is only presented after a read-enabled cycle
  p_valid_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> $past(readEn));

  // R7: at most one word per cell per conversion
  always_ff @(posedge clk) begin
    if (rst_n) p_word_budget_r7: assert (validSeen <= SEEN_W'(NUM_CELLS));
  end

  // R8: the bus holds between words
  p_quiet_bus_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dataValid |-> ($stable(dataOut) && $stable(overOut)));

  // R5: an overcount word always carries the full-scale count
  p_overflow_fullscale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dataValid && overOut) |-> (dataOut == {CNT_W{1'b1}}));

  // R9: done stays up until a start arrives
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !convStart) |=> done);

  // R9: nothing is read once done has settled
  p_no_valid_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !dataValid);

endmodule

bind ramp_conv_backend ramp_conv_backend_chk #(
  .CNT_W    (CNT_W),
  .NUM_CELLS(NUM_CELLS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .convStart(convStart),
  .readEn   (readEn),
  .dataOut  (dataOut),
  .overOut  (overOut),
  .dataValid(dataValid),
  .done     (done)
);

// File: tb/ramp_conv_backend_tb_top.sv
module ramp_conv_backend_tb_top;

  localparam int N  = 256;
  localparam int CW = 12;
  localparam int SL = 1120;

  typedef struct packed {
    logic        shortM;
    logic        glitch;
    logic        midStart;
    int unsigned mul;
    int unsigned add;
    int unsigned md;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{shortM: 1'b0, glitch: 1'b1, midStart: 1'b1, mul: 37, add: 0,   md: 4300},
    '{shortM: 1'b1, glitch: 1'b0, midStart: 1'b1, mul: 13, add: 900, md: 400},
    '{shortM: 1'b0, glitch: 1'b0, midStart: 1'b0, mul: 16, add: 5,   md: 4096},
    '{shortM: 1'b1, glitch: 1'b1, midStart: 1'b0, mul: 7,  add: 3,   md: 1500}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          convStart;
  logic          shortMode;
  logic [N-1:0]  cmpIn;
  logic          readEn;
  logic [CW-1:0] dataOut;
  logic          overOut;
  logic          dataValid;
  logic          done;

  always #10 clk = ~clk;

  ramp_conv_backend dut_i (
    .clk(clk), .rst_n(rst_n), .convStart(convStart), .shortMode(shortMode),
    .cmpIn(cmpIn), .readEn(readEn), .dataOut(dataOut), .overOut(overOut),
    .dataValid(dataValid), .done(done)
  );

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int limOf(int v);
    return VECS[v].shortM ? SL - 1 : (1 << CW) - 1;
  endfunction

  function automatic int thrOf(int v, int i);
    int t;
    t = (i * int'(VECS[v].mul) + int'(VECS[v].add)) % int'(VECS[v].md);
    if (i == 3) t = limOf(v);
    if (i == 4) t = limOf(v) + 1;
    if (i % 64 == 0) t = 0;
    return t;
  endfunction

  function automatic int expOf(int v, int i);
    int t;
    t = thrOf(v, i);
    return (t > limOf(v)) ? ((1 << CW) | ((1 << CW) - 1)) : t;
  endfunction

  function automatic logic cmpAt(int v, int i, int k);
    int t;
    logic c;
    t = thrOf(v, i);
    c = (k - 1) >= t;
    if (VECS[v].glitch && (i % 17 == 5) && (k - 1) >= t + 2 && (k - 1) <= t + 5) c = 1'b0;
    return c;
  endfunction

  task automatic runVec(input int v);
    int lim;
    lim = limOf(v);
    @(negedge clk);
    for (int i = 0; i < N; i++) cmpIn[i] = (thrOf(v, i) == 0);  // R3 pre-asserted
    shortMode = VECS[v].shortM;
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    for (int k = 1; k <= lim + 1; k++) begin
      for (int i = 0; i < N; i++) cmpIn[i] = cmpAt(v, i, k);
      convStart = (VECS[v].midStart && k == 50);   // R11 ignored start
      if (k == 10) shortMode = ~shortMode;         // R6 mode latched
      @(negedge clk);
    end
    chk(dataValid == 1'b0, "R5/R6 no word at window end", int'(dataValid), 0);
    chk(done == 1'b0, "R10 done cleared by start", int'(done), 0);
    cmpIn = '0;
    convStart = 1'b0;
    readEn = 1'b1;
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      convStart = 1'b0;
      chk(dataValid == 1'b1, "R7 valid per word", int'(dataValid), 1);
      chk(int'({overOut, dataOut}) == expOf(v, j), "R2/R3/R4/R5/R6/R7/R10 cell word",
          int'({overOut, dataOut}), expOf(v, j));
      if (j == N - 1) chk(done == 1'b1, "R9 done with last word", int'(done), 1);
      else if (j == 10) chk(done == 1'b0, "R9 done low mid-read", int'(done), 0);
      if (VECS[v].midStart && j == 200) convStart = 1'b1;  // R11 ignored start
      if (j == 100) begin
        readEn = 1'b0;
        repeat (3) begin
          @(negedge clk);
          chk(dataValid == 1'b0, "R8 paused read", int'(dataValid), 0);
          chk(int'({overOut, dataOut}) == expOf(v, j), "R8 bus held",
              int'({overOut, dataOut}), expOf(v, j));
        end
        readEn = 1'b1;
      end
    end
    repeat (3) begin
      @(negedge clk);
      chk(dataValid == 1'b0, "R9 no word after done", int'(dataValid), 0);
      chk(done == 1'b1, "R9 done sticky", int'(done), 1);
    end
    readEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    convStart = 1'b0;
    shortMode = 1'b0;
    cmpIn = '0;
    readEn = 1'b0;
    repeat (3) @(negedge clk);
    chk(dataValid == 1'b0 && done == 1'b0, "R1 in reset", int'({dataValid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dataValid == 1'b0, "R1 valid after reset", int'(dataValid), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(int'({overOut, dataOut}) == 0, "R1 bus after reset", int'({overOut, dataOut}), 0);
    readEn = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(dataValid == 1'b0, "R1 read while idle", int'(dataValid), 0);
    end
    readEn = 1'b0;
    for (int v = 0; v < NV; v++) runVec(v);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule